// File: doc/BRIEF.md
# Planar Video Write Datapath

This block turns one CPU byte write into four plane write-data bytes for a four-plane, sixteen-colour display memory. A small bank of graphics control registers, loaded through an index port and a data port, decides how the byte is transformed. The CPU byte can be rotated, replaced per plane by a fixed colour, combined with the processor latches by a logic function, and merged with the latches under a per-bit mask.

Four write modes are provided. The first is a read-modify-write path built from the rotate, the colour override and the logic function. The second copies the latches. The third writes a colour taken from the low CPU bits. The fourth is a pattern fill in which the rotated CPU byte selects between the colour and the latch. Each plane is write-enabled only when the sequencer enables it and the CPU write strobe is high. Display memory, address decoding and the sequencer are outside this block.

Top module: `gfxw_write_path`

## Requirements
- R1: An index port write keeps only bits 3:0 of the byte. `idx_rd_data` returns the kept index zero-extended to 8 bits, one cycle after the write.
- R2: A data port write loads the register chosen by the current index (0 to 8). `dat_rd_data` returns that register combinationally. The stored widths are: index 0 colour (4 bits), index 1 colour enable (4 bits), index 2 compare colour (4 bits), index 3 rotate/function (8 bits), index 4 read plane (2 bits), index 5 mode (8 bits), index 6 misc (8 bits), index 7 compare enable (4 bits), index 8 bit mask (8 bits). Bits above a register's width read as 0.
- R3: Data port writes to index 9 to 15 change no register, and reads at those indices return 0.
- R4: Reset (rst_n low) clears every register and the index to 0.
- R5: Index 3 bits 2:0 rotate the CPU byte right by 0 to 7 positions. Output bit b takes input bit (b+n) mod 8.
- R6: Index 3 bits 4:3 select the latch function for modes 0 and 2: 0 passes the data, 1 ANDs it with the latch, 2 ORs it and 3 XORs it.
- R7: Write mode 0 (mode bits 1:0 = 0) uses the rotated CPU byte for each plane, except that a plane whose colour-enable bit p is set uses colour bit p replicated to 8 bits. The logic function is applied after that choice.
- R8: Write mode 1 writes each plane's latch byte unchanged.
- R9: Write mode 2 uses CPU bit p replicated to 8 bits as plane p's data, then applies the logic function.
- R10: Write mode 3 forms a mask from the rotated CPU byte ANDed with the bit mask. Where the mask is 1 a bit takes colour bit p; where it is 0 it keeps the latch.
- R11: In every mode, a bit position whose bit-mask bit is 0 carries the latch value.
- R12: `plane_we[p]` equals `plane_en[p]` when `cpu_wr` is high and is 0 otherwise.
- R13: Mode register bits 7:2 are stored but do not change plane data.
- R14: Plane p uses latch and output bits 8p+7:8p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_wr | input | 1 | Index port write strobe |
| idx_wdata | input | 8 | Index port write byte |
| idx_rd_data | output | 8 | Current index, zero-extended |
| dat_wr | input | 1 | Data port write strobe |
| dat_wdata | input | 8 | Data port write byte |
| dat_rd_data | output | 8 | Register selected by the index |
| cpu_wr | input | 1 | CPU memory write strobe |
| cpu_data | input | 8 | CPU write byte |
| latch_in | input | 32 | Processor latches, plane p in bits 8p+7:8p |
| plane_en | input | 4 | Sequencer plane-enable mask |
| plane_wdata | output | 32 | Write data, plane p in bits 8p+7:8p |
| plane_we | output | 4 | Per-plane write enable |

## Verification
The sweep runs every write mode against every logic function and every rotate count. Each of these runs with three colour, colour-enable and bit-mask settings and eight CPU and latch pairs, and the expected bytes are computed bit by bit. Asymmetric CPU values separate rotate directions and counts. Mixed colour-enable patterns separate the per-plane override from the rotated data. Partial bit masks separate masked-out latch bits from new data. The register tests write all-ones to reach each stored width, write to indices 9 to 15 and read everything back, and set the unused mode bits to show that the plane data does not change.

// File: rtl/gfxw_pkg.sv
// Shared types for the planar write datapath.
// Assumes four planes of eight-bit bytes in the register encodings.
package gfxw_pkg;
    typedef enum logic [1:0] {
        WM_ALU   = 2'd0,
        WM_COPY  = 2'd1,
        WM_COLOR = 2'd2,
        WM_FILL  = 2'd3
    } wmode_e;

    typedef enum logic [1:0] {
        LF_PASS = 2'd0,
        LF_AND  = 2'd1,
        LF_OR   = 2'd2,
        LF_XOR  = 2'd3
    } lfunc_e;

    localparam logic [3:0] IX_COLOR  = 4'd0;
    localparam logic [3:0] IX_CEN    = 4'd1;
    localparam logic [3:0] IX_CMP    = 4'd2;
    localparam logic [3:0] IX_ROT    = 4'd3;
    localparam logic [3:0] IX_RDMAP  = 4'd4;
    localparam logic [3:0] IX_MODE   = 4'd5;
    localparam logic [3:0] IX_MISC   = 4'd6;
    localparam logic [3:0] IX_CMPEN  = 4'd7;
    localparam logic [3:0] IX_BMASK  = 4'd8;
endpackage

// File: rtl/gfxw_regs.sv
// Control register bank behind an index/data port pair.
// Assumes DW >= NPLANES and DW is a power of two. Reads are combinational.
// Writes take effect at the clock edge. Indices above 8 are not decoded.
module gfxw_regs
    import gfxw_pkg::*;
#(
    parameter int NPLANES = 4,
    parameter int DW      = 8,
    localparam int RW     = $clog2(DW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_wr,
    input  logic [7:0]         idx_wdata,
    input  logic               dat_wr,
    input  logic [DW-1:0]      dat_wdata,
    output logic [3:0]         idx_q,
    output logic [DW-1:0]      rd_data,
    output logic [NPLANES-1:0] color_q,
    output logic [NPLANES-1:0] cen_q,
    output logic [RW-1:0]      rot_cnt,
    output lfunc_e             lfunc,
    output wmode_e             wmode,
    output logic [DW-1:0]      bmask_q
);
    logic [NPLANES-1:0] cmp_q, cmpen_q;
    logic [DW-1:0]      rot_q, mode_q, misc_q;
    logic [1:0]         rdmap_q;

    // Index register keeps the low nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)      idx_q <= '0;
        else if (idx_wr) idx_q <= idx_wdata[3:0];
    end

    // Data port writes the register chosen by the index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            color_q <= '0; cen_q <= '0; cmp_q <= '0; cmpen_q <= '0;
            rot_q <= '0; mode_q <= '0; misc_q <= '0; rdmap_q <= '0;
            bmask_q <= '0;
        end else if (dat_wr) begin
            case (idx_q)
                IX_COLOR: color_q <= dat_wdata[NPLANES-1:0];
                IX_CEN:   cen_q   <= dat_wdata[NPLANES-1:0];
                IX_CMP:   cmp_q   <= dat_wdata[NPLANES-1:0];
                IX_ROT:   rot_q   <= dat_wdata;
                IX_RDMAP: rdmap_q <= dat_wdata[1:0];
                IX_MODE:  mode_q  <= dat_wdata;
                IX_MISC:  misc_q  <= dat_wdata;
                IX_CMPEN: cmpen_q <= dat_wdata[NPLANES-1:0];
                IX_BMASK: bmask_q <= dat_wdata;
                default:  ;
            endcase
        end
    end

    // Readback mux; undecoded indices return zero.
    always_comb begin
        rd_data = '0;
        case (idx_q)
            IX_COLOR: rd_data[NPLANES-1:0] = color_q;
            IX_CEN:   rd_data[NPLANES-1:0] = cen_q;
            IX_CMP:   rd_data[NPLANES-1:0] = cmp_q;
            IX_ROT:   rd_data = rot_q;
            IX_RDMAP: rd_data[1:0] = rdmap_q;
            IX_MODE:  rd_data = mode_q;
            IX_MISC:  rd_data = misc_q;
            IX_CMPEN: rd_data[NPLANES-1:0] = cmpen_q;
            IX_BMASK: rd_data = bmask_q;
            default:  rd_data = '0;
        endcase
    end

    // Decoded control fields for the datapath.
    assign rot_cnt = rot_q[RW-1:0];
    assign lfunc   = lfunc_e'(rot_q[RW+1:RW]);
    assign wmode   = wmode_e'(mode_q[1:0]);
endmodule

// File: rtl/gfxw_lane.sv
// One plane's write-data lane. It applies the colour override, the latch
// function and the bit mask for the selected write mode.
// Assumes rot_data is already rotated. Purely combinational.
module gfxw_lane
    import gfxw_pkg::*;
#(
    parameter int DW = 8
) (
    input  wmode_e        wmode,
    input  lfunc_e        lfunc,
    input  logic [DW-1:0] rot_data,
    input  logic          cpu_bit,
    input  logic          color_bit,
    input  logic          cen_bit,
    input  logic [DW-1:0] bmask,
    input  logic [DW-1:0] latch,
    output logic [DW-1:0] wdata
);
    logic [DW-1:0] src, alu, fmask;

    // Pick source byte: rotated data, colour override or CPU colour bit.
    always_comb begin
        case (wmode)
            WM_ALU:   src = cen_bit ? {DW{color_bit}} : rot_data;
            WM_COLOR: src = {DW{cpu_bit}};
            default:  src = rot_data;
        endcase
    end

    // Combine source with the latch.
    always_comb begin
        case (lfunc)
            LF_AND:  alu = src & latch;
            LF_OR:   alu = src | latch;
            LF_XOR:  alu = src ^ latch;
            default: alu = src;
        endcase
    end

    // Final merge against the latch per mode.
    always_comb begin
        fmask = rot_data & bmask;
        case (wmode)
            WM_COPY: wdata = latch;
            WM_FILL: wdata = (fmask & {DW{color_bit}}) | (~fmask & latch);
            default: wdata = (alu & bmask) | (latch & ~bmask);
        endcase
    end
endmodule

// File: rtl/gfxw_write_path.sv
// Top of the planar write datapath: register bank, CPU byte rotator and one
// lane per plane. Assumes DW >= NPLANES. Plane p is bits p*DW +: DW.
module gfxw_write_path
    import gfxw_pkg::*;
#(
    parameter int NPLANES = 4,
    parameter int DW      = 8,
    localparam int RW     = $clog2(DW),
    localparam int BW     = NPLANES * DW
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               idx_wr,
    input  logic [7:0]         idx_wdata,
    output logic [7:0]         idx_rd_data,
    input  logic               dat_wr,
    input  logic [DW-1:0]      dat_wdata,
    output logic [DW-1:0]      dat_rd_data,
    input  logic               cpu_wr,
    input  logic [DW-1:0]      cpu_data,
    input  logic [BW-1:0]      latch_in,
    input  logic [NPLANES-1:0] plane_en,
    output logic [BW-1:0]      plane_wdata,
    output logic [NPLANES-1:0] plane_we
);
    logic [3:0]         idx_q;
    logic [NPLANES-1:0] color_q, cen_q;
    logic [RW-1:0]      rot_cnt;
    lfunc_e             lfunc;
    wmode_e             wmode_q;
    logic [DW-1:0]      bitmask_q;
    logic [2*DW-1:0]    rot_wide;
    logic [DW-1:0]      rot_data;

    gfxw_regs #(.NPLANES(NPLANES), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .idx_q(idx_q), .rd_data(dat_rd_data),
        .color_q(color_q), .cen_q(cen_q),
        .rot_cnt(rot_cnt), .lfunc(lfunc),
        .wmode(wmode_q), .bmask_q(bitmask_q)
    );

    // Rotate the CPU byte right by the programmed count.
    always_comb begin
        rot_wide = {cpu_data, cpu_data} >> rot_cnt;
        rot_data = rot_wide[DW-1:0];
    end

    assign idx_rd_data = {4'b0000, idx_q};

    for (genvar p = 0; p < NPLANES; p++) begin : g_lane
        gfxw_lane #(.DW(DW)) u_lane (
            .wmode(wmode_q), .lfunc(lfunc), .rot_data(rot_data),
            .cpu_bit(cpu_data[p]), .color_bit(color_q[p]), .cen_bit(cen_q[p]),
            .bmask(bitmask_q), .latch(latch_in[p*DW +: DW]),
            .wdata(plane_wdata[p*DW +: DW])
        );
    end

    // Plane write enables gated by the CPU strobe.
    assign plane_we = plane_en & {NPLANES{cpu_wr}};
endmodule

// File: rtl/gfxw_write_path_chk.sv
// Property checker for gfxw_write_path, attached by bind below.
module gfxw_write_path_chk #(
    parameter int NPLANES = 4,
    parameter int DW      = 8,
    localparam int BW     = NPLANES * DW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               idx_wr,
    input logic [7:0]         idx_wdata,
    input logic [7:0]         idx_rd_data,
    input logic [DW-1:0]      dat_rd_data,
    input logic               cpu_wr,
    input logic [BW-1:0]      latch_in,
    input logic [NPLANES-1:0] plane_en,
    input logic [BW-1:0]      plane_wdata,
    input logic [NPLANES-1:0] plane_we,
    input logic [1:0]         wmode_q,
    input logic [DW-1:0]      bitmask_q
);
    // R1
    idx_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> idx_rd_data == {4'b0000, $past(idx_wdata[3:0])});
    // R4
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (idx_rd_data == 8'd0 && dat_rd_data == '0));
    // R8
    copy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wmode_q == 2'd1 |-> plane_wdata == latch_in);
    // R11
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((plane_wdata ^ latch_in) & ~{NPLANES{bitmask_q}}) == '0);
    // R12
    we_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |-> plane_we == '0);
    // R12
    we_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr |-> plane_we == plane_en);
endmodule

bind gfxw_write_path gfxw_write_path_chk #(.NPLANES(NPLANES), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
    .idx_rd_data(idx_rd_data), .dat_rd_data(dat_rd_data), .cpu_wr(cpu_wr),
    .latch_in(latch_in), .plane_en(plane_en), .plane_wdata(plane_wdata),
    .plane_we(plane_we), .wmode_q(wmode_q), .bitmask_q(bitmask_q)
);

// File: tb/gfxw_write_path_tb.sv
`timescale 1ns/1ps
module gfxw_write_path_tb;
    logic        clk = 0, rst_n = 0;
    logic        idx_wr = 0, dat_wr = 0, cpu_wr = 0;
    logic [7:0]  idx_wdata = 0, dat_wdata = 0, cpu_data = 0;
    logic [7:0]  idx_rd_data, dat_rd_data;
    logic [31:0] latch_in = 0, plane_wdata;
    logic [3:0]  plane_en = 0, plane_we;
    int checks = 0, errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    gfxw_write_path u_dut (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_wdata(idx_wdata),
        .idx_rd_data(idx_rd_data), .dat_wr(dat_wr), .dat_wdata(dat_wdata),
        .dat_rd_data(dat_rd_data), .cpu_wr(cpu_wr), .cpu_data(cpu_data),
        .latch_in(latch_in), .plane_en(plane_en), .plane_wdata(plane_wdata),
        .plane_we(plane_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic set_idx(input logic [7:0] v);
        @(negedge clk); idx_wr = 1; idx_wdata = v;
        @(negedge clk); idx_wr = 0;
    endtask

    task automatic wreg(input logic [7:0] ix, input logic [7:0] v);
        set_idx(ix);
        dat_wr = 1; dat_wdata = v;
        @(negedge clk); dat_wr = 0;
    endtask

    task automatic rreg(input logic [7:0] ix, output logic [7:0] v);
        set_idx(ix);
        #1 v = dat_rd_data;
    endtask

    // Reference model of one plane byte, built bit by bit from the requirements.
    function automatic logic [7:0] ref_plane(input int mode, input int fn, input int rot,
            input logic [3:0] col, input logic [3:0] cen, input logic [7:0] bm,
            input logic [7:0] cpu, input logic [7:0] lat, input int p);
        logic [7:0] r, o;
        logic s, a;
        for (int b = 0; b < 8; b++) r[b] = cpu[(b + rot) % 8];
        for (int b = 0; b < 8; b++) begin
            if (mode == 1) o[b] = lat[b];
            else if (mode == 3) o[b] = (r[b] & bm[b]) ? col[p] : lat[b];
            else begin
                s = (mode == 2) ? cpu[p] : (cen[p] ? col[p] : r[b]);
                case (fn)
                    1: a = s & lat[b];
                    2: a = s | lat[b];
                    3: a = s ^ lat[b];
                    default: a = s;
                endcase
                o[b] = bm[b] ? a : lat[b];
            end
        end
        return o;
    endfunction

    function automatic logic [31:0] ref_all(input int mode, input int fn, input int rot,
            input logic [3:0] col, input logic [3:0] cen, input logic [7:0] bm,
            input logic [7:0] cpu, input logic [31:0] lat);
        logic [31:0] v;
        for (int p = 0; p < 4; p++)
            v[p*8 +: 8] = ref_plane(mode, fn, rot, col, cen, bm, cpu, lat[p*8 +: 8], p);
        return v;
    endfunction

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] wmask [9];
        logic [3:0] cols [3];
        logic [3:0] cens [3];
        logic [7:0] bms  [3];
        wmask = '{8'h0F, 8'h0F, 8'h0F, 8'hFF, 8'h03, 8'hFF, 8'hFF, 8'h0F, 8'hFF};
        cols  = '{4'hA, 4'h5, 4'hF};
        cens  = '{4'h0, 4'h6, 4'hF};
        bms   = '{8'hFF, 8'h3C, 8'hA5};

        repeat (3) @(negedge clk);
        // R4: registers and index cleared, outputs idle, latch passes through
        latch_in = 32'h1234_5678; cpu_data = 8'h9C; plane_en = 4'hF;
        #1 chk("R4 index", {24'd0, idx_rd_data}, 32'd0);
        chk("R4 we", {28'd0, plane_we}, 32'd0);
        chk("R14 latch pass at zero mask", plane_wdata, 32'h1234_5678);
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 9; i++) begin
            rreg(i[7:0], rv);
            chk("R4 reg cleared", {24'd0, rv}, 32'd0);
        end

        // R1: index keeps the low nibble
        set_idx(8'hE3); #1 chk("R1 index nibble", {24'd0, idx_rd_data}, 32'h03);
        set_idx(8'h58); #1 chk("R1 index nibble", {24'd0, idx_rd_data}, 32'h08);

        // R2: stored widths
        for (int i = 0; i < 9; i++) begin
            wreg(i[7:0], 8'hFF); rreg(i[7:0], rv);
            chk("R2 width", {24'd0, rv}, {24'd0, wmask[i]});
        end
        for (int i = 0; i < 9; i++) wreg(i[7:0], 8'h5A + i[7:0]);
        // R3: high indices ignore writes and read zero
        for (int i = 9; i < 16; i++) begin
            wreg(8'hF0 | i[7:0], 8'hFF); rreg(i[7:0], rv);
            chk("R3 read zero", {24'd0, rv}, 32'd0);
        end
        for (int i = 0; i < 9; i++) begin
            rreg(i[7:0], rv);
            chk("R3 regs untouched", {24'd0, rv}, {24'd0, (8'h5A + i[7:0]) & wmask[i]});
        end

        // R12: enables follow strobe
        cpu_wr = 0; plane_en = 4'hF; #1 chk("R12 no strobe", {28'd0, plane_we}, 32'd0);

        // Main sweep: R5 R6 R7 R8 R9 R10 R11 R14
        for (int m = 0; m < 4; m++) begin
            wreg(8'd5, 8'h78 | m[7:0]);   // R13: bits 6:3 set but unused
            for (int f = 0; f < 4; f++) begin
                for (int r = 0; r < 8; r++) begin
                    wreg(8'd3, {3'b000, f[1:0], r[2:0]});
                    for (int c = 0; c < 3; c++) begin
                        wreg(8'd0, {4'h0, cols[c]});
                        wreg(8'd1, {4'h0, cens[c]});
                        wreg(8'd8, bms[c]);
                        for (int k = 0; k < 8; k++) begin
                            @(negedge clk);
                            cpu_data = 8'(k * 37 + 11) ^ 8'h01;
                            latch_in = {8'(k * 73), 8'(k * 29 + 200), 8'hC3 ^ 8'(k), 8'(k * 91 + 6)};
                            plane_en = k[3:0] ^ 4'h9;
                            cpu_wr = k[0];
                            #1;
                            chk(m == 0 ? "R7 R5 R6 R11 mode0" : m == 1 ? "R8 mode1" :
                                m == 2 ? "R9 R6 R11 mode2" : "R10 R5 mode3 R13",
                                plane_wdata,
                                ref_all(m, f, r, cols[c], cens[c], bms[c], cpu_data, latch_in));
                            chk("R12 we", {28'd0, plane_we},
                                {28'd0, k[0] ? (k[3:0] ^ 4'h9) : 4'h0});
                        end
                    end
                end
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule